// File: doc/BRIEF.md
# Segment Translator with Cached Descriptors

This block turns a segment selector and an offset into a 32-bit linear address. It holds a small descriptor table in internal storage. Each segment slot has its own shadow register. Software fills the table through a write port. It then loads a segment slot by presenting a selector. The block reads the descriptor once, checks the requested privilege and the present flag, and copies the base and attribute byte into that slot's shadow register. It also marks the stored descriptor as accessed.

After the load, the block never reads the table for an access. Each access names a slot, an offset and a direction. The block adds the cached base to the offset and checks the cached read or write permission. One cycle later it returns either an address strobe or a protection fault. A combinational read port exposes table entries, so software can inspect the accessed flag.

Top module: `seg_xlate`

## Requirements
- R1: While reset is held and in the first cycle after it, `ld_done`, `ld_fault`, `addr_valid` and `acc_fault` are all 0. Every shadow register starts empty, with no read or write permission, so any access to a slot that was never loaded faults.
- R2: A table entry is 64 bits. Bits [31:0] hold the base. Bits [39:32] hold the attribute byte: bit 7 present, bits 6:5 descriptor privilege level, bit 4 expand-down, bit 3 conforming, bit 2 write allowed, bit 1 read allowed, bit 0 accessed. A load whose entry is present and whose requested level is numerically less than or equal to the descriptor level copies the base and attributes into the slot. `ld_done` pulses on the cycle after `ld_valid`, with `ld_fault` = 0.
- R3: A load whose requested level is greater than the descriptor level reports `ld_fault` = 1 and leaves the slot's shadow register unchanged.
- R4: A load whose entry has the present bit clear reports `ld_fault` = 2 and leaves the shadow register unchanged. This code wins over the privilege code when both conditions hold.
- R5: A successful load sets the accessed bit (bit 32) of the table entry in the same clock edge. A failed load leaves the entry untouched.
- R6: An accepted access gives `lin_addr` = base + offset, taken modulo 2^32, together with a one-cycle `addr_valid` pulse, on the cycle after `acc_valid`.
- R7: A read to a slot without read permission, or a write to a slot without write permission, gives a one-cycle `acc_fault` pulse and no `addr_valid`.
- R8: Accesses use only the shadow copy. Rewriting a table entry after a load does not change later addresses. An access in the same cycle as a load to the same slot uses the previous shadow contents.
- R9: Selector bits [1:0] are the requested privilege level. Bits [IDXW+1:2] index the table in 8-byte entries. Selector bits above that field are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_widx | input | IDXW | Entry index to write |
| tbl_wdata | input | 64 | Entry contents to write |
| tbl_ridx | input | IDXW | Entry index to read |
| tbl_rdata | output | 64 | Entry contents, combinational |
| ld_valid | input | 1 | Load request |
| ld_seg | input | SW | Segment slot to load |
| ld_sel | input | SELW | Selector for the load |
| ld_done | output | 1 | Load completed (one-cycle pulse) |
| ld_fault | output | 2 | Load result: 0 ok, 1 privilege, 2 not present |
| acc_valid | input | 1 | Access request |
| acc_seg | input | SW | Segment slot used by the access |
| acc_off | input | AW | Offset within the segment |
| acc_wr | input | 1 | 1 for a write, 0 for a read |
| addr_valid | output | 1 | Linear address strobe |
| lin_addr | output | AW | Linear address |
| acc_fault | output | 1 | Access protection fault |

## Verification
If a shadow register held a wrong base, the next access to that slot would show an address offset by a constant. If a failed load had corrupted the slot, the access following that load would show it at once. Wrong cached permission bits show up as a fault or strobe of the wrong polarity, one cycle after the access. A lost or misdirected accessed-bit write-back shows on the table read port as soon as the load edge has passed. The bench checks each of these on the cycle right after the stimulus.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int NSEG = 4,
  parameter int IDXW = 3,
  parameter int SELW = 16,
  parameter int AW   = 32,
  localparam int SW  = $clog2(NSEG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tbl_we,
  input  logic [IDXW-1:0] tbl_widx,
  input  logic [63:0]     tbl_wdata,
  input  logic [IDXW-1:0] tbl_ridx,
  output logic [63:0]     tbl_rdata,
  input  logic            ld_valid,
  input  logic [SW-1:0]   ld_seg,
  input  logic [SELW-1:0] ld_sel,
  output logic            ld_done,
  output logic [1:0]      ld_fault,
  input  logic            acc_valid,
  input  logic [SW-1:0]   acc_seg,
  input  logic [AW-1:0]   acc_off,
  input  logic            acc_wr,
  output logic            addr_valid,
  output logic [AW-1:0]   lin_addr,
  output logic            acc_fault
);
  localparam int DEPTH = 1 << IDXW;
  localparam int ATTR  = 32;
  localparam int A_B   = 0;
  localparam int R_B   = 1;
  localparam int W_B   = 2;
  localparam int DPL_B = 5;
  localparam int P_B   = 7;

  logic [63:0] tbl [DEPTH];
  logic [NSEG-1:0][AW-1:0] shd_base;
  logic [NSEG-1:0][7:0]    shd_attr;

  wire [IDXW-1:0] lidx  = ld_sel[2 +: IDXW];
  wire [1:0]      rpl   = ld_sel[1:0];
  wire [63:0]     ldesc = tbl[lidx];
  wire [7:0]      lattr = ldesc[ATTR +: 8];
  wire            np    = !lattr[P_B];
  wire            pv    = rpl > lattr[DPL_B +: 2];
  wire            ld_ok = ld_valid && !np && !pv;

  wire [7:0] aattr = shd_attr[acc_seg];
  wire       deny  = acc_wr ? !aattr[W_B] : !aattr[R_B];

  assign tbl_rdata = tbl[tbl_ridx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
    end else begin
      if (ld_ok) tbl[lidx][ATTR + A_B] <= 1'b1;
      if (tbl_we) tbl[tbl_widx] <= tbl_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shd_base <= '0;
      shd_attr <= '0;
    end else if (ld_ok) begin
      shd_base[ld_seg] <= ldesc[AW-1:0];
      shd_attr[ld_seg] <= lattr | 8'(1 << A_B);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_done    <= 1'b0;
      ld_fault   <= 2'd0;
      addr_valid <= 1'b0;
      acc_fault  <= 1'b0;
      lin_addr   <= '0;
    end else begin
      ld_done    <= ld_valid;
      ld_fault   <= !ld_valid ? 2'd0 : np ? 2'd2 : pv ? 2'd1 : 2'd0;
      addr_valid <= acc_valid && !deny;
      acc_fault  <= acc_valid && deny;
      if (acc_valid) lin_addr <= shd_base[acc_seg] + acc_off;
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int NSEG = 4,
  parameter int SW   = 2,
  parameter int AW   = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ld_valid,
  input logic                ld_done,
  input logic [1:0]          ld_fault,
  input logic                acc_valid,
  input logic [SW-1:0]       acc_seg,
  input logic [AW-1:0]       acc_off,
  input logic                acc_wr,
  input logic                addr_valid,
  input logic [AW-1:0]       lin_addr,
  input logic                acc_fault,
  input logic [NSEG-1:0][AW-1:0] shd_base,
  input logic [NSEG-1:0][7:0]    shd_attr
);
  p_ld_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> ld_done);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_done && ld_fault != 2'd0) |-> ($stable(shd_base) && $stable(shd_attr)));

  p_acc_resp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> (addr_valid || acc_fault));

  p_addr_sum_r6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> lin_addr == $past(shd_base[acc_seg]) + $past(acc_off));

  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_valid && acc_fault));

  p_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_wr && !shd_attr[acc_seg][2]) |=> (acc_fault && !addr_valid));

  p_no_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_wr && !shd_attr[acc_seg][1]) |=> (acc_fault && !addr_valid));
endmodule

bind seg_xlate seg_xlate_chk #(.NSEG(NSEG), .SW(SW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_done(ld_done),
  .ld_fault(ld_fault), .acc_valid(acc_valid), .acc_seg(acc_seg),
  .acc_off(acc_off), .acc_wr(acc_wr), .addr_valid(addr_valid),
  .lin_addr(lin_addr), .acc_fault(acc_fault), .shd_base(shd_base),
  .shd_attr(shd_attr)
);

// File: tb/tb_seg_xlate.sv
module tb_seg_xlate;
  localparam int CLK_PERIOD = 10;
  localparam int IDXW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tbl_we = 1'b0;
  logic [IDXW-1:0] tbl_widx = '0, tbl_ridx = '0;
  logic [63:0] tbl_wdata = '0, tbl_rdata;
  logic ld_valid = 1'b0;
  logic [1:0] ld_seg = '0, acc_seg = '0, ld_fault;
  logic [15:0] ld_sel = '0;
  logic ld_done, addr_valid, acc_fault;
  logic acc_valid = 1'b0, acc_wr = 1'b0;
  logic [31:0] acc_off = '0, lin_addr;

  int n_run = 0, n_fail = 0;

  seg_xlate dut (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_widx(tbl_widx),
    .tbl_wdata(tbl_wdata), .tbl_ridx(tbl_ridx), .tbl_rdata(tbl_rdata),
    .ld_valid(ld_valid), .ld_seg(ld_seg), .ld_sel(ld_sel), .ld_done(ld_done),
    .ld_fault(ld_fault), .acc_valid(acc_valid), .acc_seg(acc_seg),
    .acc_off(acc_off), .acc_wr(acc_wr), .addr_valid(addr_valid),
    .lin_addr(lin_addr), .acc_fault(acc_fault)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {seg, wr, expect_fault, offset, expect_addr}
  localparam logic [67:0] VEC [8] = '{
    {2'd0, 1'b0, 1'b0, 32'h0000_0010, 32'h1000_0010},
    {2'd0, 1'b1, 1'b0, 32'h0000_00FF, 32'h1000_00FF},
    {2'd1, 1'b0, 1'b0, 32'h0000_0004, 32'h2000_0004},
    {2'd1, 1'b1, 1'b1, 32'h0000_0008, 32'h0000_0000},
    {2'd3, 1'b1, 1'b0, 32'h0000_0008, 32'h4000_0008},
    {2'd3, 1'b0, 1'b1, 32'h0000_0008, 32'h0000_0000},
    {2'd2, 1'b0, 1'b0, 32'h0000_2000, 32'h0000_1000},
    {2'd2, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_EFFF}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_tbl(input int idx, input logic [31:0] base, input logic [7:0] attr);
    @(negedge clk);
    tbl_we = 1'b1; tbl_widx = IDXW'(idx); tbl_wdata = {24'h0, attr, base};
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic do_load(input string req, input logic [1:0] seg, input logic [15:0] sel,
                         input logic [1:0] exp);
    @(negedge clk);
    ld_valid = 1'b1; ld_seg = seg; ld_sel = sel;
    @(negedge clk);
    ld_valid = 1'b0;
    check(req, {ld_done, ld_fault}, {1'b1, exp});
  endtask

  task automatic do_acc(input string req, input logic [1:0] seg, input logic wr,
                        input logic [31:0] off, input logic flt, input logic [31:0] exp);
    @(negedge clk);
    acc_valid = 1'b1; acc_seg = seg; acc_wr = wr; acc_off = off;
    @(negedge clk);
    acc_valid = 1'b0;
    check(req, {addr_valid, acc_fault}, {!flt, flt});
    if (!flt) check(req, lin_addr, exp);
  endtask

  task automatic rd_attr(input string req, input int idx, input logic [7:0] exp);
    tbl_ridx = IDXW'(idx);
    #1;
    check(req, tbl_rdata[39:32], exp);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R1 reset outputs", {ld_done, ld_fault, addr_valid, acc_fault}, 5'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 first cycle", {ld_done, ld_fault, addr_valid, acc_fault}, 5'b0);
    do_acc("R1 empty slot faults", 2'd0, 1'b0, 32'h0, 1'b1, 32'h0);

    wr_tbl(0, 32'h1000_0000, 8'hE6);
    wr_tbl(1, 32'h2000_0000, 8'h82);
    wr_tbl(2, 32'h3000_0000, 8'h66);
    wr_tbl(3, 32'h4000_0000, 8'hA4);
    wr_tbl(4, 32'hFFFF_F000, 8'hE6);
    wr_tbl(5, 32'h5000_0000, 8'h06);

    do_load("R2 load ok", 2'd0, 16'h0003, 2'd0);
    rd_attr("R5 accessed set", 0, 8'hE7);
    do_load("R3 privilege fault", 2'd1, 16'h0007, 2'd1);
    rd_attr("R5 untouched on fault", 1, 8'h82);
    do_acc("R3 shadow unchanged", 2'd1, 1'b0, 32'h4, 1'b1, 32'h0);
    do_load("R2 load rpl0", 2'd1, 16'h0004, 2'd0);
    do_load("R4 not present", 2'd2, 16'h0008, 2'd2);
    rd_attr("R5 untouched not present", 2, 8'h66);
    do_load("R4 priority over privilege", 2'd3, 16'h0017, 2'd2);
    do_load("R2 equal level", 2'd3, 16'h000D, 2'd0);
    do_load("R2 load wrap base", 2'd2, 16'h0012, 2'd0);

    for (int i = 0; i < 8; i++) begin
      do_acc(VEC[i][65] ? "R7 vector" : "R6 vector", VEC[i][67:66], VEC[i][65],
             VEC[i][63:32], VEC[i][64], VEC[i][31:0]);
    end

    do_load("R4 failed reload", 2'd2, 16'h0008, 2'd2);
    do_acc("R4 shadow kept", 2'd2, 1'b0, 32'h10, 1'b0, 32'hFFFF_F010);

    wr_tbl(0, 32'h5555_0000, 8'hE6);
    do_acc("R8 table rewrite ignored", 2'd0, 1'b0, 32'h20, 1'b0, 32'h1000_0020);

    @(negedge clk);
    ld_valid = 1'b1; ld_seg = 2'd1; ld_sel = 16'h0000;
    acc_valid = 1'b1; acc_seg = 2'd1; acc_wr = 1'b0; acc_off = 32'h4;
    @(negedge clk);
    ld_valid = 1'b0; acc_valid = 1'b0;
    check("R8 same-cycle load", {ld_done, ld_fault}, 3'b100);
    check("R8 same-cycle old base", {addr_valid, lin_addr}, {1'b1, 32'h2000_0004});
    do_acc("R8 new base after load", 2'd1, 1'b1, 32'h4, 1'b0, 32'h5555_0004);

    do_load("R9 upper selector bits ignored", 2'd3, 16'hFFF3, 2'd0);
    do_acc("R9 index field used", 2'd3, 1'b1, 32'h1, 1'b0, 32'hFFFF_F001);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule